// File: doc/BRIEF.md
# External SRAM Access Timing Sequencer

This block produces the chip-select, read-strobe and write-strobe waveforms for a single external static-memory area. A 32-bit timing control register holds two fields: a setup code that sets how long chip-select and address lead the strobe, and a wait code that stretches the strobe. When the internal bus raises a request, the sequencer latches the address and direction. It drives chip-select and address at once. After the programmed setup delay it asserts the read or write strobe for the stretched access. It then releases strobe and chip-select together and pulses a completion flag.

The sequencer runs on a clock at twice the external bus rate. A half bus cycle is therefore one tick, and a full bus cycle is two ticks. The timing for an access is captured when the request is accepted, so writes to the control register during an access only apply to the following access. Wait codes 13 to 15 are not legal settings. If one is written, the register keeps the code, every access uses the longest wait, and a sticky error flag is raised.

Top module: `sram_tmg_seq`

## Requirements
- R1: After reset the control register reads 0x00000500 (setup code 0, wait code 10), the error flag is 0, and chip-select, both strobes and the done flag are low.
- R2: Writes store bits 12:11 as the setup code and bits 10:7 as the wait code. Bits 31:13 and 6:0 always read as 0, whatever is written to them.
- R3: Chip-select rises in the tick after a request is accepted. The strobe follows after 2*S+1 ticks of setup, where S is the setup code, so setup codes 0 to 3 give 0.5, 1.5, 2.5 and 3.5 bus cycles.
- R4: The strobe is held for 2*(1+W) ticks. W is the decoded wait count: codes 0 to 6 give 0 to 6, and codes 7, 8, 9, 10, 11 and 12 give 8, 10, 12, 14, 18 and 24.
- R5: With wait codes 13, 14 or 15 the strobe is held for 50 ticks (24 wait cycles), and the register still reads back the written code.
- R6: Writing a wait code of 13 or more sets the error flag. The flag stays set through later legal writes and is cleared only by reset.
- R7: A read request asserts only the read strobe and a write request asserts only the write strobe. The address output shows the latched request address for as long as chip-select is high.
- R8: In the tick where the strobe and chip-select both fall, done is high for exactly one tick.
- R9: A request seen while an access is in progress starts no access. Chip-select stays low after done while the sequencer is idle and the request has been withdrawn.
- R10: A register write made during an access does not change that access's timing. It applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the external bus rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing control register |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| cfg_err | output | 1 | Sticky flag: an illegal wait code was written |
| req | input | 1 | Access request, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| mem_addr | output | ADDR_W | Address driven to memory |
| mem_cs | output | 1 | Chip-select, active high |
| mem_rd | output | 1 | Read strobe, active high |
| mem_we | output | 1 | Write strobe, active high |
| done | output | 1 | One-tick completion pulse |

## Verification
The bench targets the irregular top of the wait table (codes 7 to 12), where a linear decode would give 7 to 12 cycles instead of 8 to 24. It also targets the illegal codes: a design that wrapped or truncated them would produce a short strobe or none. Setup is counted to the tick, because an off-by-one would drop the half cycle and make code 0 a zero-length setup. Requests arriving mid-access and register writes made mid-access are also exercised. A sequencer that re-reads the live register, or accepts while busy, would stretch the current strobe or start a second access right after done.

// File: rtl/sram_tmg_pkg.sv
package sram_tmg_pkg;

    localparam int REG_W    = 32;
    localparam int SETUP_W  = 2;
    localparam int WAIT_W   = 4;
    localparam int SETUP_LO = 11;
    localparam int WAIT_LO  = 7;
    localparam int SETUP_HI = SETUP_LO + SETUP_W - 1;
    localparam int WAIT_HI  = WAIT_LO + WAIT_W - 1;
    localparam int MAX_WAIT = 24;
    localparam int LAST_OK  = 12;
    localparam int CYC_W    = $clog2(MAX_WAIT + 1);
    localparam int TICK_W   = $clog2(2 * (MAX_WAIT + 1) + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [WAIT_W-1:0]  waitc;
    } tmg_cfg_t;

    localparam tmg_cfg_t CFG_RESET = '{setup: 2'd0, waitc: 4'd10};

    function automatic logic code_bad(input logic [WAIT_W-1:0] c);
        return c > WAIT_W'(LAST_OK);
    endfunction

    function automatic logic [CYC_W-1:0] wait_cycles(input logic [WAIT_W-1:0] c);
        logic [CYC_W-1:0] r;
        if (c <= 4'd6) r = CYC_W'(c);
        else begin
            case (c)
                4'd7:    r = CYC_W'(8);
                4'd8:    r = CYC_W'(10);
                4'd9:    r = CYC_W'(12);
                4'd10:   r = CYC_W'(14);
                4'd11:   r = CYC_W'(18);
                default: r = CYC_W'(MAX_WAIT);
            endcase
        end
        return r;
    endfunction

    // counter preload: ticks spent = preload + 1
    function automatic logic [TICK_W-1:0] setup_preload(input logic [SETUP_W-1:0] s);
        return TICK_W'({s, 1'b0});
    endfunction

    function automatic logic [TICK_W-1:0] strobe_preload(input logic [WAIT_W-1:0] c);
        return TICK_W'({wait_cycles(c), 1'b0}) + TICK_W'(1);
    endfunction

endpackage

// File: rtl/sram_tmg_regs.sv
module sram_tmg_regs
    import sram_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output tmg_cfg_t         cfg,
    output logic             err
);

    tmg_cfg_t cfg_q;
    logic     err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else if (we) begin
            cfg_q.setup <= wdata[SETUP_HI:SETUP_LO];
            cfg_q.waitc <= wdata[WAIT_HI:WAIT_LO];
            if (code_bad(wdata[WAIT_HI:WAIT_LO])) err_q <= 1'b1;
        end
    end

    always_comb begin
        rdata                    = '0;
        rdata[SETUP_HI:SETUP_LO] = cfg_q.setup;
        rdata[WAIT_HI:WAIT_LO]   = cfg_q.waitc;
    end

    assign cfg = cfg_q;
    assign err = err_q;

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    a_r6_err_on_bad: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[WAIT_HI:WAIT_LO] > 4'd12) |=> err_q);
    a_r2_field_kept: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata[WAIT_HI:WAIT_LO] == $past(wdata[WAIT_HI:WAIT_LO])));

endmodule

// File: rtl/sram_tmg_fsm.sv
module sram_tmg_fsm
    import sram_tmg_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  tmg_cfg_t          cfg,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs,
    output logic              mem_rd,
    output logic              mem_we,
    output logic              done
);

    seq_state_e        state_q;
    logic [TICK_W-1:0] cnt_q;
    logic [TICK_W-1:0] hold_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic              strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req) begin
                    state_q <= ST_SETUP;
                    cnt_q   <= setup_preload(cfg.setup);
                    hold_q  <= strobe_preload(cfg.waitc);
                    wr_q    <= req_write;
                    addr_q  <= req_addr;
                end
                ST_SETUP: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_STROBE;
                        cnt_q   <= hold_q;
                    end else cnt_q <= cnt_q - 1'b1;
                end
                ST_STROBE: begin
                    if (cnt_q == '0) state_q <= ST_DONE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign strobe   = (state_q == ST_STROBE);
    assign mem_cs   = (state_q == ST_SETUP) || strobe;
    assign mem_rd   = strobe && !wr_q;
    assign mem_we   = strobe && wr_q;
    assign done     = (state_q == ST_DONE);
    assign mem_addr = addr_q;

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));
    a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_we) |-> mem_cs);
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_at_release: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe) |-> (done && !mem_cs));
    a_r7_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && $past(mem_cs)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_tmg_seq.sv
module sram_tmg_seq
    import sram_tmg_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_err,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs,
    output logic              mem_rd,
    output logic              mem_we,
    output logic              done
);

    tmg_cfg_t cfg;

    sram_tmg_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg),
        .err   (cfg_err)
    );

    sram_tmg_fsm #(.ADDR_W(ADDR_W)) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .req       (req),
        .req_write (req_write),
        .req_addr  (req_addr),
        .mem_addr  (mem_addr),
        .mem_cs    (mem_cs),
        .mem_rd    (mem_rd),
        .mem_we    (mem_we),
        .done      (done)
    );

endmodule

// File: tb/test_sram_tmg_seq.sv
module test_sram_tmg_seq;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          cfg_err;
    logic          req = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_cs, mem_rd, mem_we, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sram_tmg_seq #(.ADDR_W(AW)) i_sram_tmg_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .req(req),
        .req_write(req_write), .req_addr(req_addr), .mem_addr(mem_addr),
        .mem_cs(mem_cs), .mem_rd(mem_rd), .mem_we(mem_we), .done(done)
    );

    // setup(2) wait(4) write(1) expected setup ticks(8) expected strobe ticks(8)
    localparam logic [22:0] VEC [12] = '{
        {2'd0, 4'd0,  1'b0, 8'd1, 8'd2},
        {2'd1, 4'd1,  1'b1, 8'd3, 8'd4},
        {2'd2, 4'd6,  1'b0, 8'd5, 8'd14},
        {2'd3, 4'd7,  1'b1, 8'd7, 8'd18},
        {2'd0, 4'd8,  1'b0, 8'd1, 8'd22},
        {2'd1, 4'd9,  1'b1, 8'd3, 8'd26},
        {2'd2, 4'd10, 1'b0, 8'd5, 8'd30},
        {2'd3, 4'd11, 1'b1, 8'd7, 8'd38},
        {2'd0, 4'd12, 1'b0, 8'd1, 8'd50},
        {2'd0, 4'd5,  1'b1, 8'd1, 8'd12},
        {2'd1, 4'd13, 1'b0, 8'd3, 8'd50},
        {2'd2, 4'd15, 1'b1, 8'd5, 8'd50}
    };

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(input logic [1:0] s, input logic [3:0] w);
        return {19'd0, s, w, 7'd0};
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic run_access(input bit wr, input logic [AW-1:0] a,
                              input bit mid_en, input logic [31:0] mid_val,
                              input bit hold_req,
                              output int su, output int st,
                              output bit addr_ok, output bit dir_ok, output bit done_ok);
        bit prev_strobe = 1'b0;
        bit seen = 1'b0;
        su = 0; st = 0; addr_ok = 1'b1; dir_ok = 1'b1; done_ok = 1'b1;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a;
        for (int t = 0; t < 200 && !seen; t++) begin
            @(negedge clk);
            if (!hold_req) req = 1'b0;
            if (mid_en && t == 0) begin cfg_we = 1'b1; cfg_wdata = mid_val; end
            else cfg_we = 1'b0;
            if (done) begin
                seen = 1'b1;
                if (mem_cs || mem_rd || mem_we || !prev_strobe) done_ok = 1'b0;
                req = 1'b0;
            end else if (mem_cs) begin
                if (mem_addr != a) addr_ok = 1'b0;
                if (mem_rd || mem_we) begin
                    st++;
                    if (mem_rd == wr || mem_we != wr) dir_ok = 1'b0;
                end else begin
                    su++;
                    if (st != 0) dir_ok = 1'b0;
                end
                prev_strobe = mem_rd || mem_we;
            end else done_ok = 1'b0;
        end
        if (!seen) done_ok = 1'b0;
        @(negedge clk);
        if (done) done_ok = 1'b0;
    endtask

    initial begin
        int su, st;
        bit aok, dok, nok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 32'h500, "R1 reset value", cfg_rdata, 32'h500);
        chk(!cfg_err, "R1 error flag", cfg_err, 0);
        chk(!(mem_cs || mem_rd || mem_we || done), "R1 bus idle",
            {mem_cs, mem_rd, mem_we, done}, 0);

        // R2 reserved bits read zero; R6 bad code sets flag
        write_cfg(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h0000_1F80, "R2 reserved bits", cfg_rdata, 32'h1F80);
        chk(cfg_err, "R6 flag on bad write", cfg_err, 1);
        write_cfg(32'h0000_0A7F);
        chk(cfg_rdata == 32'h0000_0A00, "R2 fields kept", cfg_rdata, 32'h0A00);
        chk(cfg_err, "R6 flag sticky after legal write", cfg_err, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!cfg_err && cfg_rdata == 32'h500, "R6 reset clears flag",
            {cfg_err, cfg_rdata}, 32'h500);

        // vector walk: R3 R4 R5 R7 R8
        for (int i = 0; i < 12; i++) begin
            logic [22:0] v;
            v = VEC[i];
            write_cfg(mkcfg(v[22:21], v[20:17]));
            chk(cfg_rdata == mkcfg(v[22:21], v[20:17]), "R5 readback of code",
                cfg_rdata, mkcfg(v[22:21], v[20:17]));
            if (i == 9) chk(!cfg_err, "R6 no flag for legal codes", cfg_err, 0);
            run_access(v[16], AW'(24'h1000 + i * 24'h111), 1'b0, '0, 1'b0,
                       su, st, aok, dok, nok);
            chk(su == int'(v[15:8]), "R3 setup ticks", su, v[15:8]);
            chk(st == int'(v[7:0]), v[20:17] > 4'd12 ? "R5 prohibited code strobe"
                                                   : "R4 strobe ticks", st, v[7:0]);
            chk(aok && dok, "R7 address and direction", {aok, dok}, 2'b11);
            chk(nok, "R8 done pulse", nok, 1);
        end
        chk(cfg_err, "R6 flag after prohibited codes", cfg_err, 1);

        // R10 mid-access write applies next time
        write_cfg(mkcfg(2'd0, 4'd0));
        run_access(1'b0, 24'hABCDE, 1'b1, mkcfg(2'd0, 4'd12), 1'b0, su, st, aok, dok, nok);
        chk(su == 1 && st == 2, "R10 current access unchanged", st, 2);
        run_access(1'b1, 24'h12345, 1'b0, '0, 1'b0, su, st, aok, dok, nok);
        chk(su == 1 && st == 50, "R10 next access uses new value", st, 50);

        // R9 request held during access ignored
        write_cfg(mkcfg(2'd1, 4'd2));
        run_access(1'b0, 24'h00F0F, 1'b0, '0, 1'b1, su, st, aok, dok, nok);
        chk(su == 3 && st == 6, "R9 single access timing", st, 6);
        begin
            bit quiet = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (mem_cs || mem_rd || mem_we || done) quiet = 1'b0;
            end
            chk(quiet, "R9 no second access", quiet, 1);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule